// File: doc/BRIEF.md
# Signed Halfword Multiply-Accumulate Unit

This unit performs signed multiplies on the half-width parts of word-wide operands. It has four operations. The first multiplies one halfword by another and gives a full word. The second multiplies a full word by a halfword and keeps the upper word of the product. The third does the same and adds the result to a word accumulator. The fourth adds a halfword-by-halfword product to a double-word accumulator, which is supplied as a high word and a low word. Each operand halfword can be taken from the top or the bottom of its word, and is sign-extended before it is multiplied.

An operation is presented on the input pins together with a one-cycle strobe. The result appears on registered outputs one clock later. The word accumulate operation can overflow as a signed addition. When it does, the unit still returns the wrapped sum, and it raises a one-cycle overflow pulse. The surrounding logic can collect that pulse into a sticky flag.

Top module: `shmac_unit`

## Requirements
- R1: For the halfword-by-halfword operations (op 00 and op 11), `sel_a_top`=1 takes bits [W-1:W/2] of `opa` and 0 takes bits [W/2-1:0]. `sel_b_top` picks a half of `opb` in the same way in every operation.
- R2: Every selected halfword is treated as a two's-complement value and is sign-extended from its top bit before the multiply.
- R3: Op 00 returns the W-bit signed product of the two selected halfwords on `res_lo`. In this operation `res_hi` is 0 and `ovf_pulse` is 0.
- R4: Op 01 multiplies the whole signed `opa` by the selected signed half of `opb`. It shifts the product right arithmetically by W/2 and returns product bits [3W/2-1:W/2] on `res_lo`. In this operation `res_hi` is 0 and `ovf_pulse` is 0.
- R5: Op 10 adds the op 01 value to `acc` and returns the sum modulo 2^W on `res_lo`, with no saturation. In this operation `res_hi` is 0.
- R6: `ovf_pulse` is 1 for exactly the result cycle of an op 10 whose addition overflows as a signed W-bit sum. In every other cycle it is 0.
- R7: Op 11 forms {`acc_hi`,`acc_lo`}, adds the sign-extended op 00 product modulo 2^(2W), and returns the sum split into `res_hi` (upper word) and `res_lo` (lower word). This operation never pulses `ovf_pulse`.
- R8: A strobe on `in_valid` at a rising clock edge produces `out_valid`=1 together with its result after that edge. With no strobe, `out_valid` is 0 after the edge.
- R9: In cycles without a strobe, `res_lo` and `res_hi` keep their last values.
- R10: Synchronous reset clears `out_valid`, `res_lo`, `res_hi` and `ovf_pulse` to 0.
- R11: In op 01 and op 10, `sel_a_top` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 half mul, 01 word-by-half mul, 10 word-by-half accumulate, 11 long accumulate |
| sel_a_top | input | 1 | Take top half of `opa` (half-by-half ops) |
| sel_b_top | input | 1 | Take top half of `opb` |
| opa | input | W | First operand |
| opb | input | W | Second operand |
| acc | input | W | Word accumulator for op 10 |
| acc_hi | input | W | Upper word of long accumulator |
| acc_lo | input | W | Lower word of long accumulator |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| res_lo | output | W | Result word / lower word of long result |
| res_hi | output | W | Upper word of long result, else 0 |
| ovf_pulse | output | 1 | Accumulate overflow pulse for the sticky flag |

## Verification
The bench builds the unit with W=8, so each halfword is 4 bits wide. At that width it can drive every pair of operand values, 65,536 strobes in all. The operation and the half-select bits rotate across the sweep, and the accumulator values are derived from the operands. That covers every halfword product and every sign combination, including most-negative times most-negative, and both directions of accumulate overflow. Directed cases then hit the exact overflow edges, carry and borrow across the long-accumulator word boundary, hold cycles, and toggling of the ignored select.

// File: rtl/shmac_pkg.sv
package shmac_pkg;

    typedef enum logic [1:0] {
        OP_HH_MUL  = 2'b00,
        OP_WH_MUL  = 2'b01,
        OP_WH_MAC  = 2'b10,
        OP_HH_LACC = 2'b11
    } shmac_op_e;

    // Signed overflow of an addition from the two addend signs and the sum sign.
    function automatic logic add_ovf(input logic sign_a, input logic sign_b, input logic sign_s);
        return (sign_a == sign_b) && (sign_s != sign_a);
    endfunction

    // True for operations that choose the first operand's halfword.
    function automatic logic uses_a_half(input shmac_op_e op);
        return (op == OP_HH_MUL) || (op == OP_HH_LACC);
    endfunction

endpackage

// File: rtl/shmac_half_pick.sv
module shmac_half_pick #(
    parameter int W = 32,
    localparam int H = W / 2
) (
    input  logic [W-1:0]        word,
    input  logic                top,
    output logic signed [H-1:0] half
);
    always_comb begin
        half = top ? word[W-1:H] : word[H-1:0];
    end
endmodule

// File: rtl/shmac_hh_mul.sv
module shmac_hh_mul #(
    parameter int W = 32,
    localparam int H = W / 2
) (
    input  logic signed [H-1:0] ha,
    input  logic signed [H-1:0] hb,
    output logic signed [W-1:0] prod
);
    logic signed [W-1:0] ha_x;
    logic signed [W-1:0] hb_x;

    always_comb begin
        ha_x = W'(ha);
        hb_x = W'(hb);
        prod = ha_x * hb_x;
    end
endmodule

// File: rtl/shmac_wh_mac.sv
module shmac_wh_mac
    import shmac_pkg::*;
#(
    parameter int W = 32,
    localparam int H = W / 2,
    localparam int PW = W + H
) (
    input  logic signed [W-1:0] wa,
    input  logic signed [H-1:0] hb,
    input  logic        [W-1:0] acc,
    output logic        [W-1:0] scaled,
    output logic        [W-1:0] sum,
    output logic                ovf
);
    logic signed [PW-1:0] wa_x;
    logic signed [PW-1:0] hb_x;
    logic signed [PW-1:0] full;

    always_comb begin
        wa_x   = PW'(wa);
        hb_x   = PW'(hb);
        full   = wa_x * hb_x;
        scaled = full[PW-1:H];
        sum    = scaled + acc;
        ovf    = add_ovf(scaled[W-1], acc[W-1], sum[W-1]);
    end
endmodule

// File: rtl/shmac_long_acc.sv
module shmac_long_acc #(
    parameter int W = 32,
    localparam int DW = 2 * W
) (
    input  logic [W-1:0] prod,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    output logic [W-1:0] sum_hi,
    output logic [W-1:0] sum_lo
);
    logic [DW-1:0] base;
    logic [DW-1:0] addend;
    logic [DW-1:0] total;

    always_comb begin
        base   = {acc_hi, acc_lo};
        addend = {{W{prod[W-1]}}, prod};
        total  = base + addend;
        sum_hi = total[DW-1:W];
        sum_lo = total[W-1:0];
    end
endmodule

// File: rtl/shmac_unit.sv
module shmac_unit
    import shmac_pkg::*;
#(
    parameter int W = 32,
    localparam int H = W / 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [1:0]   op_sel,
    input  logic         sel_a_top,
    input  logic         sel_b_top,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] acc,
    input  logic [W-1:0] acc_hi,
    input  logic [W-1:0] acc_lo,
    output logic         out_valid,
    output logic [W-1:0] res_lo,
    output logic [W-1:0] res_hi,
    output logic         ovf_pulse
);
    shmac_op_e           op;
    logic signed [H-1:0] half_a;
    logic signed [H-1:0] half_b;
    logic signed [W-1:0] hh_prod;
    logic        [W-1:0] wh_scaled;
    logic        [W-1:0] wh_sum;
    logic                wh_ovf;
    logic        [W-1:0] la_hi;
    logic        [W-1:0] la_lo;
    logic        [W-1:0] nxt_lo;
    logic        [W-1:0] nxt_hi;
    logic                nxt_ovf;

    assign op = shmac_op_e'(op_sel);

    shmac_half_pick #(.W(W)) u_pick_a (.word(opa), .top(sel_a_top), .half(half_a));
    shmac_half_pick #(.W(W)) u_pick_b (.word(opb), .top(sel_b_top), .half(half_b));

    shmac_hh_mul #(.W(W)) u_hh_mul (.ha(half_a), .hb(half_b), .prod(hh_prod));

    shmac_wh_mac #(.W(W)) u_wh_mac (
        .wa(opa), .hb(half_b), .acc(acc),
        .scaled(wh_scaled), .sum(wh_sum), .ovf(wh_ovf)
    );

    shmac_long_acc #(.W(W)) u_long_acc (
        .prod(hh_prod), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .sum_hi(la_hi), .sum_lo(la_lo)
    );

    always_comb begin
        nxt_lo  = '0;
        nxt_hi  = '0;
        nxt_ovf = 1'b0;
        unique case (op)
            OP_HH_MUL:  nxt_lo = hh_prod;
            OP_WH_MUL:  nxt_lo = wh_scaled;
            OP_WH_MAC: begin
                nxt_lo  = wh_sum;
                nxt_ovf = wh_ovf;
            end
            OP_HH_LACC: begin
                nxt_lo = la_lo;
                nxt_hi = la_hi;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_lo    <= '0;
            res_hi    <= '0;
            ovf_pulse <= 1'b0;
        end else begin
            out_valid <= in_valid;
            ovf_pulse <= in_valid & nxt_ovf;
            if (in_valid) begin
                res_lo <= nxt_lo;
                res_hi <= nxt_hi;
            end
        end
    end
endmodule

// File: rtl/shmac_unit_chk.sv
module shmac_unit_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [1:0]   op_sel,
    input logic         out_valid,
    input logic [W-1:0] res_lo,
    input logic [W-1:0] res_hi,
    input logic         ovf_pulse
);
    // R8: a strobe yields a valid result one cycle later
    a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8: no strobe, no valid
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R9: results hold without a strobe
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_lo) && $stable(res_hi)));

    // R6: pulse only with a valid result
    a_r6_pulse_valid: assert property (@(posedge clk) disable iff (rst)
        ovf_pulse |-> out_valid);

    // R6: only the word accumulate op can pulse
    a_r6_pulse_op: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel != 2'b10) |=> !ovf_pulse);

    // R3 R4 R5: word-sized ops leave the upper word at zero
    a_r3_hi_zero: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_sel != 2'b11) |=> (res_hi == '0));
endmodule

bind shmac_unit shmac_unit_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi), .ovf_pulse(ovf_pulse)
);

// File: tb/shmac_unit_bench.sv
module shmac_unit_bench;
    localparam int W = 8;
    localparam int H = W / 2;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [1:0]   op_sel;
    logic         sel_a_top;
    logic         sel_b_top;
    logic [W-1:0] opa, opb, acc, acc_hi, acc_lo;
    logic         out_valid;
    logic [W-1:0] res_lo, res_hi;
    logic         ovf_pulse;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    shmac_unit #(.W(W)) u_shmac_unit (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
        .sel_a_top(sel_a_top), .sel_b_top(sel_b_top),
        .opa(opa), .opb(opb), .acc(acc), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .out_valid(out_valid), .res_lo(res_lo), .res_hi(res_hi), .ovf_pulse(ovf_pulse)
    );

    function automatic longint sx(longint v, int bits);
        longint r;
        r = v & ((longint'(1) << bits) - 1);
        if (r >= (longint'(1) << (bits - 1))) r = r - (longint'(1) << bits);
        return r;
    endfunction

    task automatic check(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Drive one strobe, then compare the registered result against the model.
    task automatic run(string tag, int op, bit sa, bit sb,
                       longint a, longint b, longint c, longint chi, longint clo);
        longint ha, hb, p, s, sum, wide, mask, exp_lo, exp_hi;
        bit exp_q;
        mask = (longint'(1) << W) - 1;
        ha = sx(sa ? (a >> H) : a, H);
        hb = sx(sb ? (b >> H) : b, H);
        p = ha * hb;
        s = (sx(a, W) * hb) >>> H;
        exp_hi = 0;
        exp_q = 1'b0;
        case (op)
            0: exp_lo = p & mask;
            1: exp_lo = s & mask;
            2: begin
                sum = s + sx(c, W);
                exp_lo = sum & mask;
                exp_q = (sum > (mask >> 1)) || (sum < -((mask >> 1) + 1));
            end
            default: begin
                wide = ((chi & mask) << W) + (clo & mask) + p;
                exp_lo = wide & mask;
                exp_hi = (wide >> W) & mask;
            end
        endcase
        @(negedge clk);
        in_valid = 1'b1; op_sel = 2'(op); sel_a_top = sa; sel_b_top = sb;
        opa = W'(a); opb = W'(b); acc = W'(c); acc_hi = W'(chi); acc_lo = W'(clo);
        @(posedge clk);
        #1;
        check(tag, "valid R8", longint'(out_valid), 1);
        check(tag, "res_lo", longint'(res_lo), exp_lo);
        check(tag, "res_hi", longint'(res_hi), exp_hi);
        check(tag, "ovf R6", longint'(ovf_pulse), longint'(exp_q));
    endtask

    // A cycle with no strobe: garbage on the data pins must not disturb the outputs.
    task automatic idle_check();
        logic [W-1:0] keep_lo, keep_hi;
        @(negedge clk);
        keep_lo = res_lo; keep_hi = res_hi;
        in_valid = 1'b0; op_sel = 2'b10; opa = '1; opb = '1; acc = 8'h7F;
        acc_hi = 8'h5A; acc_lo = 8'hA5;
        @(posedge clk);
        #1;
        check("R8", "valid low", longint'(out_valid), 0);
        check("R9", "hold lo", longint'(res_lo), longint'(keep_lo));
        check("R9", "hold hi", longint'(res_hi), longint'(keep_hi));
        check("R6", "no pulse idle", longint'(ovf_pulse), 0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; op_sel = '0; sel_a_top = 1'b0; sel_b_top = 1'b0;
        opa = '0; opb = '0; acc = '0; acc_hi = '0; acc_lo = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R10", "reset valid", longint'(out_valid), 0);
        check("R10", "reset lo", longint'(res_lo), 0);
        check("R10", "reset hi", longint'(res_hi), 0);
        check("R10", "reset ovf", longint'(ovf_pulse), 0);
        @(negedge clk);
        rst = 1'b0;

        // Full operand sweep, R1 R2 with each op: R3, R4 R11, R5, R7
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                int op;
                bit sa, sb;
                string tg;
                op = (a + b) & 3;
                sa = bit'((a >> 1) ^ b);
                sb = bit'((b >> 2) ^ a);
                case (op)
                    0: tg = "R1 R2 R3";
                    1: tg = "R2 R4 R11";
                    2: tg = "R5 R11";
                    default: tg = "R1 R7";
                endcase
                run(tg, op, sa, sb, a, b, (a * 7 + b * 13) & 255,
                    (a ^ 8'h80) & 255, (b * 3) & 255);
            end
            if ((a & 31) == 0) idle_check();
        end

        // R6 overflow edges for op 10
        run("R5 R6 pos ovf", 2, 0, 0, 8'h7F, 8'h07, 8'h7F, 0, 0);
        run("R5 R6 neg ovf", 2, 0, 0, 8'h80, 8'h07, 8'h80, 0, 0);
        run("R6 edge no ovf", 2, 0, 0, 8'h7F, 8'h07, 8'd72, 0, 0);
        run("R6 edge ovf", 2, 1, 0, 8'h7F, 8'h07, 8'd73, 0, 0);
        run("R6 neg edge", 2, 0, 1, 8'h80, 8'h70, 8'h80, 0, 0);
        // R6 pulse lasts one cycle
        idle_check();
        // R7 carry, borrow, wrap
        run("R7 carry", 3, 0, 0, 8'h01, 8'h01, 0, 8'h00, 8'hFF);
        run("R7 borrow", 3, 0, 0, 8'h0F, 8'h01, 0, 8'h01, 8'h00);
        run("R7 wrap", 3, 1, 1, 8'h10, 8'h10, 0, 8'h7F, 8'hFF);
        run("R7 min*min", 3, 1, 1, 8'h80, 8'h80, 0, 8'hFF, 8'hC0);
        // R11: toggling the first select in ops 01 and 10
        run("R4 R11 sa0", 1, 0, 1, 8'hB3, 8'h9C, 0, 0, 0);
        run("R4 R11 sa1", 1, 1, 1, 8'hB3, 8'h9C, 0, 0, 0);
        run("R5 R11 sa0", 2, 0, 0, 8'h6D, 8'h0E, 8'h44, 0, 0);
        run("R5 R11 sa1", 2, 1, 0, 8'h6D, 8'h0E, 8'h44, 0, 0);
        // R3 most-negative halves
        run("R2 R3 min*min", 0, 1, 0, 8'h80, 8'h08, 0, 0, 0);
        idle_check();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule